// File: doc/BRIEF.md
# Password Access Level Controller

This block decides what a host may touch in a paged 256-byte register map. The host writes a 32-bit password, one byte at a time, into a window of four write-only entry bytes. The block compares the live entry with two reference passwords and grants one of three cumulative privilege levels. The level-1 password comes from table 3 storage. The level-2 password is fixed.

The lower half of the map (addresses below 80h) is shared by every page. The upper half is the page chosen by a table-select byte. For each byte access, the block tells the storage arrays whether to perform the read or the write. It also masks the returned data to 00h when a read is refused. The entry bytes and the table-select byte are held inside the block.

The privilege level behaves as a three-state machine:
- USER (0) is the state whenever the entry matches neither password.
- MFG1 (1) is entered when the entry equals the level-1 password.
- MFG2 (2) is entered when the entry equals the level-2 password.

Every write to an entry byte is a transition. The state is re-evaluated against both passwords after each such write and takes effect on the next cycle. Reset forces the entry to all ones, which normally lands in USER.

Top module: `pwac_top`

## Requirements
- R1: After reset the entry holds FFFFFFFFh and the table select holds 0. With passwords other than all ones the level is 0. If the level-1 password is FFFFFFFFh, level 1 is granted straight out of reset.
- R2: Entry bytes sit at 7Bh (bits 31:24), 7Ch, 7Dh and 7Eh (bits 7:0). An entry equal to the level-2 password gives level 2 (`access_level`=2). This takes precedence when both passwords are equal.
- R3: An entry equal to the level-1 password, and not to the level-2 password, gives level 1 (`access_level`=1).
- R4: The level follows the entry register on the cycle after each entry write. Changing one entry byte away from a match drops the level to 0.
- R5: Reads of 7Bh to 7Eh return 00h and never assert `rd_allow`. Writes there never assert `wr_allow`.
- R6: A write of 00h to 03h at 7Fh sets the table select. A larger value is ignored. A read of 7Fh returns the selection in bits 1:0 without asserting `rd_allow`.
- R7: Lower addresses 00h to 6Dh and 70h to 7Ah are readable at any level. They are writable only at level 2.
- R8: 6Fh is writable at any level. 6Eh is never writable.
- R9: With table 0 selected, upper reads return 00h and upper writes are dropped, at every level.
- R10: Table 1 upper is readable and writable at level 1 or 2.
- R11: Tables 2 and 3 upper are readable and writable only at level 2.
- R12: A refused read returns 00h regardless of `store_rdata`. A refused write asserts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_addr | input | 8 | Byte address of the host access |
| acc_wdata | input | 8 | Write data |
| acc_wr | input | 1 | Write strobe, one cycle per byte |
| acc_rd | input | 1 | Read strobe |
| store_rdata | input | 8 | Data returned by the storage arrays |
| pw_lvl1 | input | 32 | Stored level-1 password |
| pw_lvl2 | input | 32 | Fixed level-2 password |
| access_level | output | 2 | Current level: 0 user, 1, 2 |
| table_sel | output | 2 | Selected upper table |
| rd_allow | output | 1 | Forward the read to storage |
| wr_allow | output | 1 | Forward the write to storage |
| rd_data | output | 8 | Masked read data to the host |

## Verification
The same set of addresses is probed at each of the three levels. This separates a permission that depends on the level from one that depends on the region or on the table. The password is entered one byte at a time, so the bench sees both the dropped level that a single mismatched byte causes and the grant that only the final byte completes.

Two corner cases are tried on purpose:
- Out-of-range table-select values, to show the previous selection is kept.
- Equal passwords and an all-ones level-1 password, to show level 2 takes precedence and to expose the power-up hazard.

// File: rtl/pwac_pkg.sv
package pwac_pkg;
    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_MFG1 = 2'd1,
        LVL_MFG2 = 2'd2
    } lvl_e;

    typedef enum logic [2:0] {
        RG_LOW_PROT,
        RG_LOW_RO,
        RG_LOW_OPEN,
        RG_ENTRY,
        RG_TSEL,
        RG_UPPER
    } region_e;
endpackage

// File: rtl/pwac_entry_reg.sv
module pwac_entry_reg #(
    parameter int PW_W   = 32,
    parameter int DATA_W = 8,
    parameter int TSEL_W = 2,
    localparam int PW_BYTES = PW_W / DATA_W,
    localparam int IDX_W    = $clog2(PW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_entry,
    input  logic [IDX_W-1:0]  entry_idx,
    input  logic              wr_tsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [PW_W-1:0]   entry,
    output logic [TSEL_W-1:0] tsel
);
    // Byte 0 of the window is the most significant byte.
    for (genvar i = 0; i < PW_BYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry[PW_W-1-i*DATA_W -: DATA_W] <= '1;
            end else if (wr_entry && entry_idx == IDX_W'(i)) begin
                entry[PW_W-1-i*DATA_W -: DATA_W] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsel <= '0;
        end else if (wr_tsel) begin
            tsel <= wdata[TSEL_W-1:0];
        end
    end
endmodule

// File: rtl/pwac_level_cmp.sv
module pwac_level_cmp
    import pwac_pkg::*;
#(
    parameter int PW_W = 32
) (
    input  logic [PW_W-1:0] entry,
    input  logic [PW_W-1:0] pw_lvl1,
    input  logic [PW_W-1:0] pw_lvl2,
    output lvl_e            level
);
    // Level 2 is checked first so it wins when both passwords are equal.
    always_comb begin
        if (entry == pw_lvl2)      level = LVL_MFG2;
        else if (entry == pw_lvl1) level = LVL_MFG1;
        else                       level = LVL_USER;
    end
endmodule

// File: rtl/pwac_region_dec.sv
module pwac_region_dec
    import pwac_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              PW_BYTES   = 4,
    parameter logic [ADDR_W-1:0] ENTRY_BASE = 8'h7B,
    parameter logic [ADDR_W-1:0] TSEL_ADDR  = 8'h7F,
    parameter logic [ADDR_W-1:0] RO_ADDR    = 8'h6E,
    parameter logic [ADDR_W-1:0] OPEN_ADDR  = 8'h6F,
    localparam int IDX_W = $clog2(PW_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  entry_idx
);
    localparam logic [ADDR_W-1:0] ENTRY_LAST = ENTRY_BASE + ADDR_W'(PW_BYTES - 1);

    assign entry_idx = addr[IDX_W-1:0] - ENTRY_BASE[IDX_W-1:0];

    always_comb begin
        if (addr[ADDR_W-1])                                region = RG_UPPER;
        else if (addr == RO_ADDR)                          region = RG_LOW_RO;
        else if (addr == OPEN_ADDR)                        region = RG_LOW_OPEN;
        else if (addr >= ENTRY_BASE && addr <= ENTRY_LAST) region = RG_ENTRY;
        else if (addr == TSEL_ADDR)                        region = RG_TSEL;
        else                                               region = RG_LOW_PROT;
    end
endmodule

// File: rtl/pwac_access_gate.sv
module pwac_access_gate
    import pwac_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int TSEL_W    = 2,
    parameter int MAX_TABLE = 3
) (
    input  region_e           region,
    input  lvl_e              level,
    input  logic [TSEL_W-1:0] tsel,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] store_rdata,
    output logic              rd_allow,
    output logic              wr_allow,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_entry,
    output logic              wr_tsel
);
    logic rd_ok, wr_ok, int_rd, is_l2, is_l1p;

    assign is_l2  = (level == LVL_MFG2);
    assign is_l1p = (level != LVL_USER);

    always_comb begin
        rd_ok    = 1'b0;
        wr_ok    = 1'b0;
        int_rd   = 1'b0;
        wr_entry = 1'b0;
        wr_tsel  = 1'b0;
        unique case (region)
            RG_LOW_PROT: begin rd_ok = 1'b1; wr_ok = is_l2; end
            RG_LOW_RO:   begin rd_ok = 1'b1; end
            RG_LOW_OPEN: begin rd_ok = 1'b1; wr_ok = 1'b1; end
            RG_ENTRY:    begin wr_entry = acc_wr; end
            RG_TSEL: begin
                wr_tsel = acc_wr && (wdata <= DATA_W'(MAX_TABLE));
                int_rd  = acc_rd;
            end
            RG_UPPER: begin
                unique case (tsel)
                    TSEL_W'(0): begin rd_ok = 1'b0;   wr_ok = 1'b0;   end
                    TSEL_W'(1): begin rd_ok = is_l1p; wr_ok = is_l1p; end
                    default:    begin rd_ok = is_l2;  wr_ok = is_l2;  end
                endcase
            end
            default: begin rd_ok = 1'b0; wr_ok = 1'b0; end
        endcase
    end

    assign rd_allow = acc_rd && rd_ok;
    assign wr_allow = acc_wr && wr_ok;
    assign rd_data  = rd_allow ? store_rdata : (int_rd ? DATA_W'(tsel) : '0);
endmodule

// File: rtl/pwac_top.sv
module pwac_top
    import pwac_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PW_W      = 32,
    parameter int MAX_TABLE = 3,
    localparam int TSEL_W   = $clog2(MAX_TABLE + 1),
    localparam int PW_BYTES = PW_W / DATA_W,
    localparam int IDX_W    = $clog2(PW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [DATA_W-1:0] store_rdata,
    input  logic [PW_W-1:0]   pw_lvl1,
    input  logic [PW_W-1:0]   pw_lvl2,
    output logic [1:0]        access_level,
    output logic [TSEL_W-1:0] table_sel,
    output logic              rd_allow,
    output logic              wr_allow,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] ENTRY_BASE = ADDR_W'(8'h7B);
    localparam logic [ADDR_W-1:0] TSEL_ADDR  = ADDR_W'(8'h7F);
    localparam logic [ADDR_W-1:0] RO_ADDR    = ADDR_W'(8'h6E);
    localparam logic [ADDR_W-1:0] OPEN_ADDR  = ADDR_W'(8'h6F);
    localparam logic [ADDR_W-1:0] ID_END     = ADDR_W'(8'h60);

    region_e          region;
    lvl_e             level;
    logic [IDX_W-1:0] entry_idx;
    logic [PW_W-1:0]  entry;
    logic             wr_entry, wr_tsel;

    pwac_region_dec #(
        .ADDR_W(ADDR_W), .PW_BYTES(PW_BYTES), .ENTRY_BASE(ENTRY_BASE),
        .TSEL_ADDR(TSEL_ADDR), .RO_ADDR(RO_ADDR), .OPEN_ADDR(OPEN_ADDR)
    ) u_dec (
        .addr(acc_addr), .region(region), .entry_idx(entry_idx)
    );

    pwac_entry_reg #(.PW_W(PW_W), .DATA_W(DATA_W), .TSEL_W(TSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_entry(wr_entry), .entry_idx(entry_idx),
        .wr_tsel(wr_tsel), .wdata(acc_wdata), .entry(entry), .tsel(table_sel)
    );

    pwac_level_cmp #(.PW_W(PW_W)) u_cmp (
        .entry(entry), .pw_lvl1(pw_lvl1), .pw_lvl2(pw_lvl2), .level(level)
    );

    pwac_access_gate #(.DATA_W(DATA_W), .TSEL_W(TSEL_W), .MAX_TABLE(MAX_TABLE)) u_gate (
        .region(region), .level(level), .tsel(table_sel), .acc_rd(acc_rd),
        .acc_wr(acc_wr), .wdata(acc_wdata), .store_rdata(store_rdata),
        .rd_allow(rd_allow), .wr_allow(wr_allow), .rd_data(rd_data),
        .wr_entry(wr_entry), .wr_tsel(wr_tsel)
    );

    assign access_level = level;

    assert_low_wr_needs_l2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allow && acc_addr < ID_END) |-> access_level == 2'd2);

    assert_tsel_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == TSEL_ADDR && acc_wdata > DATA_W'(MAX_TABLE)) |=> $stable(table_sel));

    assert_entry_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_addr >= ENTRY_BASE && acc_addr < TSEL_ADDR) |-> (!rd_allow && rd_data == '0));

    assert_table0_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[ADDR_W-1] && table_sel == '0) |-> (!rd_allow && !wr_allow));

    assert_io_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == RO_ADDR) |-> !wr_allow);
endmodule

// File: tb/pwac_top_test.sv
module pwac_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 34;
    localparam logic [31:0] PW1 = 32'h1234_5678;
    localparam logic [31:0] PW2 = 32'hCAFE_F00D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_addr = '0, acc_wdata = '0, store_rdata = 8'hA5, rd_data;
    logic       acc_wr = 1'b0, acc_rd = 1'b0, rd_allow, wr_allow;
    logic [31:0] pw_lvl1 = PW1, pw_lvl2 = PW2;
    logic [1:0] access_level, table_sel;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwac_top uut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .store_rdata(store_rdata),
        .pw_lvl1(pw_lvl1), .pw_lvl2(pw_lvl2), .access_level(access_level),
        .table_sel(table_sel), .rd_allow(rd_allow), .wr_allow(wr_allow), .rd_data(rd_data)
    );

    // {is_rd, addr, wdata, exp_allow, exp_rdata, exp_level_after, req}
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 8'h00, 1'b1, 8'hA5, 2'd0, 4'd7},  // R7 lower read at level 0
        {1'b0, 8'h00, 8'h11, 1'b0, 8'h00, 2'd0, 4'd7},  // R7 lower write refused
        {1'b0, 8'h6F, 8'h00, 1'b1, 8'h00, 2'd0, 4'd8},  // R8 update byte open
        {1'b0, 8'h6E, 8'h00, 1'b0, 8'h00, 2'd0, 4'd8},  // R8 io byte read-only
        {1'b1, 8'h7B, 8'h00, 1'b0, 8'h00, 2'd0, 4'd5},  // R5 entry reads 00
        {1'b1, 8'h80, 8'h00, 1'b0, 8'h00, 2'd0, 4'd9},  // R9 table 0 read
        {1'b0, 8'h80, 8'h00, 1'b0, 8'h00, 2'd0, 4'd9},  // R9 table 0 write
        {1'b0, 8'h7F, 8'h01, 1'b0, 8'h00, 2'd0, 4'd6},  // R6 select table 1
        {1'b1, 8'h7F, 8'h00, 1'b0, 8'h01, 2'd0, 4'd6},  // R6 read back select
        {1'b1, 8'h80, 8'h00, 1'b0, 8'h00, 2'd0, 4'd12}, // R12 refused read masked
        {1'b0, 8'h7B, 8'h12, 1'b0, 8'h00, 2'd0, 4'd3},  // R3 entry msb
        {1'b0, 8'h7C, 8'h34, 1'b0, 8'h00, 2'd0, 4'd3},
        {1'b0, 8'h7D, 8'h56, 1'b0, 8'h00, 2'd0, 4'd3},
        {1'b0, 8'h7E, 8'h78, 1'b0, 8'h00, 2'd1, 4'd3},  // R3 level 1 granted
        {1'b1, 8'h80, 8'h00, 1'b1, 8'hA5, 2'd1, 4'd10}, // R10 table 1 read
        {1'b0, 8'h90, 8'h22, 1'b1, 8'h00, 2'd1, 4'd10}, // R10 table 1 write
        {1'b0, 8'h00, 8'h33, 1'b0, 8'h00, 2'd1, 4'd7},  // R7 level 1 lower write refused
        {1'b0, 8'h7F, 8'h05, 1'b0, 8'h00, 2'd1, 4'd6},  // R6 out of range ignored
        {1'b1, 8'h7F, 8'h00, 1'b0, 8'h01, 2'd1, 4'd6},
        {1'b0, 8'h7F, 8'h02, 1'b0, 8'h00, 2'd1, 4'd6},
        {1'b1, 8'h80, 8'h00, 1'b0, 8'h00, 2'd1, 4'd11}, // R11 table 2 closed at level 1
        {1'b0, 8'h7B, 8'hCA, 1'b0, 8'h00, 2'd0, 4'd4},  // R4 one byte drops level
        {1'b0, 8'h7C, 8'hFE, 1'b0, 8'h00, 2'd0, 4'd2},  // R2 entry build
        {1'b0, 8'h7D, 8'hF0, 1'b0, 8'h00, 2'd0, 4'd2},
        {1'b0, 8'h7E, 8'h0D, 1'b0, 8'h00, 2'd2, 4'd2},  // R2 level 2 granted
        {1'b1, 8'h80, 8'h00, 1'b1, 8'hA5, 2'd2, 4'd11}, // R11 table 2 read
        {1'b0, 8'h80, 8'h44, 1'b1, 8'h00, 2'd2, 4'd11}, // R11 table 2 write
        {1'b0, 8'h7F, 8'h03, 1'b0, 8'h00, 2'd2, 4'd6},
        {1'b0, 8'hC0, 8'h55, 1'b1, 8'h00, 2'd2, 4'd11}, // R11 table 3 write
        {1'b0, 8'h00, 8'h66, 1'b1, 8'h00, 2'd2, 4'd7},  // R7 level 2 lower write
        {1'b1, 8'h7E, 8'h00, 1'b0, 8'h00, 2'd2, 4'd5},  // R5 entry read still 00
        {1'b0, 8'h7F, 8'h00, 1'b0, 8'h00, 2'd2, 4'd6},
        {1'b1, 8'h80, 8'h00, 1'b0, 8'h00, 2'd2, 4'd9},  // R9 table 0 closed at level 2
        {1'b0, 8'h6E, 8'h77, 1'b0, 8'h00, 2'd2, 4'd8}   // R8 io byte at level 2
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit is_rd, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_rd = is_rd; acc_wr = !is_rd;
        #1;
    endtask

    task automatic finish_access();
        @(posedge clk); #1;
        acc_rd = 1'b0; acc_wr = 1'b0;
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin @(posedge clk); wd++; end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(access_level == 2'd0, "R1 level", 32'(access_level), 0);
        check(table_sel == 2'd0, "R1 tsel", 32'(table_sel), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            logic allow;
            v = VEC[i];
            access(v[31], v[30:23], v[22:15]);
            allow = v[31] ? rd_allow : wr_allow;
            check(allow == v[14] && (v[31] ? !wr_allow : !rd_allow) && rd_data == v[13:6],
                  $sformatf("R%0d vec%0d allow/data", v[3:0], i),
                  {23'd0, allow, rd_data}, {23'd0, v[14], v[13:6]});
            finish_access();
            check(access_level == v[5:4], $sformatf("R%0d vec%0d level", v[3:0], i),
                  32'(access_level), 32'(v[5:4]));
        end

        // R2 precedence: both passwords equal to the entry
        pw_lvl1 = PW2; #1;
        check(access_level == 2'd2, "R2 precedence", 32'(access_level), 2);
        pw_lvl1 = PW1;

        // R1 reset restores all-ones entry and table 0
        rst_n = 1'b0; #2 rst_n = 1'b1;
        access(1'b1, 8'h7F, 8'h00);
        check(rd_data == 8'h00 && access_level == 2'd0, "R1 after reset",
              {access_level, rd_data}, 0);
        finish_access();
        // R1 hazard: all-ones level-1 password grants level 1 at reset
        pw_lvl1 = 32'hFFFF_FFFF; #1;
        check(access_level == 2'd1, "R1 all-ones hazard", 32'(access_level), 1);
        // R4 changing one entry byte removes the grant
        access(1'b0, 8'h7E, 8'h00);
        finish_access();
        check(access_level == 2'd0, "R4 partial entry", 32'(access_level), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule